// File: doc/BRIEF.md
# Bidirectional Ordered Pulse Sequencer

This block turns each rising edge of a slow main clock into a burst of five short enable pulses that never overlap. The pulses drive a chain of latches that shifts data one place per main-clock cycle. The first pulse always goes to the holding latch that buffers the incoming bit. The other four go to the four data latches of a group. They fire in the order that lets each latch copy its neighbour before that neighbour is overwritten. Two sets of outputs exist, one for shifting right and one for shifting left. Only the set chosen by the direction captured at the edge is active.

The model runs on a fast tick clock. The main clock arrives as a level input and is sampled on that tick clock. Three parameters, counted in ticks, fix the timing: the start delay, the pulse width and the pulse spacing. The default width of 3 ticks and spacing of 4 ticks give a width to spacing ratio of 75:100 with one idle tick between neighbouring pulses. If a main-clock edge arrives while a burst is still running, the block flags an overrun.

Top module: `pulse_seq`

## Requirements
- R1: After reset and between bursts, all ten pulse outputs are low. Only a rising edge of `main_clk`, seen by comparing two successive tick samples, starts a burst.
- R2: The tick edge that first samples `main_clk` high is the start tick. Pulse slot k (k = 0..4) is high for the ticks that begin on tick edge start + START_TICKS + k*SPACE_TICKS and on the next WIDTH_TICKS-1 tick edges. Slot 0 is always the holding-latch pulse.
- R3: With `dir_right` = 1, slots 1 to 4 drive `rt_dat[3]`, `rt_dat[2]`, `rt_dat[1]` and `rt_dat[0]` in that order. Bit index j of the data vector is data latch j+1.
- R4: With `dir_right` = 0, slots 1 to 4 drive `lf_dat[0]`, `lf_dat[1]`, `lf_dat[2]` and `lf_dat[3]` in that order.
- R5: No two of the ten pulse outputs are ever high in the same tick. In the tick where one pulse falls, all outputs are low.
- R6: During a burst, every output of the unselected direction stays low.
- R7: `dir_right` is captured at the start tick. Changing it during a burst has no effect on that burst.
- R8: A rising edge of `main_clk` during a burst, before its final tick, is ignored: the running burst continues unchanged. `overrun` goes high for exactly the one tick after that edge.
- R9: A rising edge sampled on the tick edge that ends a burst (the burst's final tick) starts a new burst at once and does not raise `overrun`.
- R10: Synchronous active-high `rst` clears any burst and `overrun`. A `main_clk` held high through reset does not start a burst when reset is released.
- R11: Holding `main_clk` high for many ticks produces exactly one burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast tick clock |
| rst | input | 1 | Synchronous active-high reset |
| main_clk | input | 1 | Main clock level, sampled on each tick |
| dir_right | input | 1 | 1 selects right shifting, 0 selects left shifting |
| rt_tmp | output | 1 | Holding-latch pulse, right shifting |
| rt_dat | output | 4 | Data-latch pulses, right shifting (bit j is latch j+1) |
| lf_tmp | output | 1 | Holding-latch pulse, left shifting |
| lf_dat | output | 4 | Data-latch pulses, left shifting (bit j is latch j+1) |
| overrun | output | 1 | One-tick flag: an edge arrived during a busy burst |

## Verification
The hardest case to reach from the ports is the exact boundary between an overrun and a clean restart. To reach it, the rising edge of `main_clk` must land precisely on the burst's final tick, or exactly one tick earlier. The stimulus uses its own tick-offset model of the running burst. It waits until that model reaches each of those two offsets, with `main_clk` already low, and then raises `main_clk`. Random toggling of the main clock, the direction and reset is added on top, so that overruns, direction flips during a burst and resets during a burst occur many times.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

    localparam int unsigned SLOTS      = 5;
    localparam int unsigned DATA_LANES = SLOTS - 1;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic                  tmp;
        logic [DATA_LANES-1:0] dat;
    } lane_set_t;

    // slot that feeds data lane j when shifting right (highest lane first)
    function automatic int unsigned rt_slot_of(input int unsigned lane);
        return DATA_LANES - lane;
    endfunction

    // slot that feeds data lane j when shifting left (lowest lane first)
    function automatic int unsigned lf_slot_of(input int unsigned lane);
        return lane + 1;
    endfunction

    function automatic int unsigned burst_len(input int unsigned start_t,
                                              input int unsigned width_t,
                                              input int unsigned space_t);
        return start_t + (SLOTS - 1) * space_t + width_t;
    endfunction

endpackage

// File: rtl/ps_trigger.sv
module ps_trigger
    import pulse_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       main_clk,
    input  logic       dir_right,
    input  logic       busy,
    input  logic       last,
    output logic       start,
    output shift_dir_e dir_q,
    output logic       overrun
);

    logic mclk_q;
    logic rise;

    assign rise  = main_clk & ~mclk_q;
    assign start = rise & (~busy | last);

    always_ff @(posedge clk) begin
        if (rst) begin
            mclk_q  <= main_clk;
            dir_q   <= DIR_LEFT;
            overrun <= 1'b0;
        end else begin
            mclk_q  <= main_clk;
            overrun <= rise & busy & ~last;
            if (start) begin
                dir_q <= dir_right ? DIR_RIGHT : DIR_LEFT;
            end
        end
    end

    // R8: the flag only follows a tick in which a burst was running
    a_r8_overrun_needs_busy: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(busy));

    // R7: direction stays put while a burst runs without a restart
    a_r7_dir_held: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> $stable(dir_q));

endmodule

// File: rtl/ps_timer.sv
module ps_timer
    import pulse_seq_pkg::*;
#(
    parameter int unsigned START_TICKS = 1,
    parameter int unsigned WIDTH_TICKS = 3,
    parameter int unsigned SPACE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             last,
    output logic [SLOTS-1:0] slot_act
);

    localparam int unsigned BURST = burst_len(START_TICKS, WIDTH_TICKS, SPACE_TICKS);
    localparam int unsigned LAST  = BURST - 1;
    localparam int unsigned CNT_W = $clog2(BURST + 1);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);
    localparam logic [CNT_W:0]   WID_V  = (CNT_W+1)'(WIDTH_TICKS);

    logic [CNT_W-1:0] cnt;

    assign last = busy && (cnt == LAST_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam logic [CNT_W:0] OPEN_V = (CNT_W+1)'(START_TICKS + k * SPACE_TICKS);
        logic [CNT_W:0] rel;
        assign rel         = {1'b0, cnt} - OPEN_V;
        assign slot_act[k] = busy && (rel < WID_V);

        // R5: when a slot closes, every slot is closed
        a_r5_clean_handoff: assert property (@(posedge clk) disable iff (rst)
            $fell(slot_act[k]) |-> (slot_act == '0));
    end

    // R5: at most one slot open per tick
    a_r5_one_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_act));

endmodule

// File: rtl/ps_router.sv
module ps_router
    import pulse_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  shift_dir_e       dir_q,
    input  logic [SLOTS-1:0] slot_act,
    output lane_set_t        rt_set,
    output lane_set_t        lf_set
);

    logic go_rt;
    assign go_rt = (dir_q == DIR_RIGHT);

    assign rt_set.tmp = go_rt  & slot_act[0];
    assign lf_set.tmp = ~go_rt & slot_act[0];

    for (genvar j = 0; j < DATA_LANES; j++) begin : g_lane
        assign rt_set.dat[j] = go_rt  & slot_act[rt_slot_of(j)];
        assign lf_set.dat[j] = ~go_rt & slot_act[lf_slot_of(j)];
    end

    // R6: the side not chosen stays silent
    a_r6_left_quiet: assert property (@(posedge clk) disable iff (rst)
        go_rt |-> (lf_set == '0));
    a_r6_right_quiet: assert property (@(posedge clk) disable iff (rst)
        !go_rt |-> (rt_set == '0));

endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
    import pulse_seq_pkg::*;
#(
    parameter int unsigned START_TICKS = 1,
    parameter int unsigned WIDTH_TICKS = 3,
    parameter int unsigned SPACE_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       main_clk,
    input  logic       dir_right,
    output logic       rt_tmp,
    output logic [3:0] rt_dat,
    output logic       lf_tmp,
    output logic [3:0] lf_dat,
    output logic       overrun
);

    logic             start;
    logic             busy;
    logic             last;
    shift_dir_e       dir_q;
    logic [SLOTS-1:0] slot_act;
    lane_set_t        rt_set;
    lane_set_t        lf_set;

    ps_trigger u_trigger (
        .clk       (clk),
        .rst       (rst),
        .main_clk  (main_clk),
        .dir_right (dir_right),
        .busy      (busy),
        .last      (last),
        .start     (start),
        .dir_q     (dir_q),
        .overrun   (overrun)
    );

    ps_timer #(
        .START_TICKS (START_TICKS),
        .WIDTH_TICKS (WIDTH_TICKS),
        .SPACE_TICKS (SPACE_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .last     (last),
        .slot_act (slot_act)
    );

    ps_router u_router (
        .clk      (clk),
        .rst      (rst),
        .dir_q    (dir_q),
        .slot_act (slot_act),
        .rt_set   (rt_set),
        .lf_set   (lf_set)
    );

    assign rt_tmp = rt_set.tmp;
    assign rt_dat = rt_set.dat;
    assign lf_tmp = lf_set.tmp;
    assign lf_dat = lf_set.dat;

    // R1: outputs silent outside a burst
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ({rt_tmp, rt_dat, lf_tmp, lf_dat} == '0));

endmodule

// File: tb/pulse_seq_bench.sv
module pulse_seq_bench;

    localparam int unsigned ST = 1;
    localparam int unsigned WD = 3;
    localparam int unsigned SP = 4;
    localparam int unsigned LAST = ST + 4 * SP + WD - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, main_clk, dir_right;
    logic       rt_tmp, lf_tmp, overrun;
    logic [3:0] rt_dat, lf_dat;

    pulse_seq #(.START_TICKS(ST), .WIDTH_TICKS(WD), .SPACE_TICKS(SP)) u_pulse_seq (
        .clk(clk), .rst(rst), .main_clk(main_clk), .dir_right(dir_right),
        .rt_tmp(rt_tmp), .rt_dat(rt_dat), .lf_tmp(lf_tmp), .lf_dat(lf_dat),
        .overrun(overrun)
    );

    int    checks = 0;
    int    errors = 0;
    string req    = "R10";
    bit    done_flag = 0;

    // bench model: ticks since the accepted edge, from the requirements
    bit m_busy = 0, m_dir = 0, m_prev = 0, m_ovr = 0;
    int m_off = 0;

    // expected {rt_tmp, rt_dat, lf_tmp, lf_dat} for offset and direction (R2..R4)
    function automatic logic [9:0] expect_out(input bit busy, input int off, input bit dr);
        logic [9:0] v = '0;
        if (!busy) return v;
        for (int k = 0; k < 5; k++) begin
            int open_t = ST + k * SP;
            if (off >= open_t && off < open_t + WD) begin
                if (k == 0) begin
                    if (dr) v[9] = 1'b1; else v[4] = 1'b1;
                end else if (dr) begin
                    v[5 + (4 - k)] = 1'b1;   // right: lane 3,2,1,0
                end else begin
                    v[k - 1] = 1'b1;         // left: lane 0,1,2,3
                end
            end
        end
        return v;
    endfunction

    task automatic step(input bit mc, input bit d, input bit r);
        logic [9:0] got, exp;
        bit edge_s, fin;
        main_clk  = mc;
        dir_right = d;
        rst       = r;
        if (r) begin
            m_busy = 0; m_off = 0; m_ovr = 0; m_prev = mc;
        end else begin
            edge_s = mc && !m_prev;
            fin    = m_busy && (m_off == LAST);
            m_ovr  = edge_s && m_busy && !fin;
            if (edge_s && (!m_busy || fin)) begin
                m_busy = 1; m_off = 0; m_dir = d;
            end else if (fin) begin
                m_busy = 0; m_off = 0;
            end else if (m_busy) begin
                m_off++;
            end
            m_prev = mc;
        end
        @(posedge clk);
        @(negedge clk);
        got = {rt_tmp, rt_dat, lf_tmp, lf_dat};
        exp = expect_out(m_busy, m_off, m_dir);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s pulses got=%b expected=%b offset=%0d", req, got, exp, m_off);
        end
        checks++;
        if (overrun !== m_ovr) begin
            errors++;
            $display("FAIL R8 overrun got=%b expected=%b", overrun, m_ovr);
        end
        checks++;
        if ($countones(got) > 1) begin
            errors++;
            $display("FAIL R5 overlap got=%b expected=at most one bit", got);
        end
    endtask

    task automatic idle(input int n, input bit d);
        for (int i = 0; i < n; i++) step(1'b0, d, 1'b0);
    endtask

    initial begin
        main_clk = 0; dir_right = 0; rst = 1;
        void'($urandom(32'd7719));

        // R10: reset state with main_clk held high
        req = "R10";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0);
        idle(3, 1'b0);

        // R1: quiet while idle
        req = "R1";
        idle(5, 1'b0);

        // R3 / R11: right burst, main_clk held high long
        req = "R3";
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0);
        req = "R11";
        idle(4, 1'b1);

        // R4 / R2: left burst
        req = "R4";
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < LAST + 3; i++) step(1'b0, 1'b0, 1'b0);

        // R7: direction flips every tick during a burst
        req = "R7";
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < LAST + 2; i++) step(1'b0, i[0], 1'b0);

        // R8: edge mid-burst, and one tick before the end
        req = "R8";
        step(1'b1, 1'b0, 1'b0);
        while (m_off != 6) step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        while (m_off != LAST - 1) step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        idle(4, 1'b0);

        // R9: edge exactly on the final tick restarts without overrun
        req = "R9";
        step(1'b1, 1'b1, 1'b0);
        while (m_off != LAST) step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < LAST + 2; i++) step(1'b0, 1'b0, 1'b0);

        // R10: reset mid-burst cancels it
        req = "R10";
        step(1'b1, 1'b1, 1'b0);
        while (m_off != 6) step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        idle(LAST + 2, 1'b1);

        // R5 / R6: random main clock, direction and reset
        req = "R6";
        begin
            bit mc = 0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 7 == 0) mc = ~mc;
                step(mc, 1'($urandom), ($urandom % 250) == 0);
            end
        end
        idle(LAST + 2, 1'b0);

        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule